// File: doc/BRIEF.md
# Return-to-zero inverted serial infrared modulator and demodulator

This block sits between a serial bit source and an optical transceiver for the two slower infrared link rates. On the transmit side it takes one bit per bit period from a level-held bit input. A zero becomes a short light pulse at the start of the period. A one leaves the emitter dark. On the receive side it watches the detector line and rebuilds the bit stream. A bit window holding a rising edge reads as zero. An empty window reads as one.

The bit period is sixteen sub-ticks, and each sub-tick lasts `tick_div + 1` system clocks, so one clock gives a range of baud rates. A mode input sets the pulse width. The narrow mode drives three sub-ticks and the medium mode drives four. The receiver restarts its bit timer on every detected edge, so it follows a far end whose clock runs a little fast or slow. Framing, checksums, buffering and any host access belong to the surrounding logic.

Top module: `irx_rzi_codec`

## Requirements
- R1: When a zero bit is loaded, `ir_tx` goes high in the first clock of that bit period.
- R2: When a one bit is loaded, `ir_tx` stays low for the whole bit period.
- R3: With `pulse_mode` = 0 (narrow), the pulse for a zero bit lasts exactly 3*(tick_div+1) clocks, covering sub-ticks 0 to 2.
- R4: With `pulse_mode` = 1 (medium), the pulse for a zero bit lasts exactly 4*(tick_div+1) clocks, covering sub-ticks 0 to 3.
- R5: A bit period lasts 16*(tick_div+1) clocks. Consecutive loaded bits follow each other with no gap.
- R6: `tx_next` is high for exactly one clock, the first clock of each bit period. The bit on `tx_bit` is sampled on the clock edge just before that clock, when `tx_valid` is high and the transmitter is idle or in the last clock of a bit.
- R7: When `tx_valid` is low at the end of a bit period, or while the transmitter is idle, `ir_tx` stays low.
- R8: The receiver emits one bit per window as a one-clock `rx_valid` pulse. `rx_bit` is 0 if a rising edge of `ir_rx` fell in that window and 1 otherwise, so the transmitted stream looped back is reproduced in order.
- R9: After reset the receiver emits nothing until it sees the first rising edge of `ir_rx`.
- R10: Every rising edge restarts the receive bit timer. An edge in the first half of a window marks that window. An edge in the second half first closes the current window, then opens a new marked one. Decoding therefore survives a far-end bit period up to about two clocks per bit off nominal.
- R11: During reset `ir_tx`, `tx_next` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_mode | input | 1 | 0 = narrow pulse (3/16), 1 = medium pulse (4/16) |
| tick_div | input | DIV_W | System clocks per sub-tick, minus one |
| tx_valid | input | 1 | A bit is offered on `tx_bit` |
| tx_bit | input | 1 | Bit value to send |
| tx_next | output | 1 | One-clock pulse at the start of each sent bit |
| ir_tx | output | 1 | Emitter drive, high = light |
| ir_rx | input | 1 | Detector output, high = light |
| rx_valid | output | 1 | One-clock strobe, a decoded bit is on `rx_bit` |
| rx_bit | output | 1 | Decoded bit value |

## Verification
The bench uses the default parameters: sixteen sub-ticks per bit, an 8-bit divisor and two input synchronizer stages. It varies `tick_div` over 0 to 3 in both pulse modes, so pulse widths and bit periods at several sub-tick lengths are compared clock by clock against a behavioural model. Looping the emitter back into the detector checks the decode of mixed bit patterns. Hand-driven pulse trains at 34 and 30 clocks per bit, with divisor 1 (32 clocks nominal), exercise both resynchronisation branches of the receiver.

// File: rtl/irx_pkg.sv
// Package irx_pkg
// Shared types for the infrared bit modulator and demodulator.
package irx_pkg;

    // Pulse width selection for the transmitter
    typedef enum logic {
        IRX_NARROW = 1'b0,
        IRX_MEDIUM = 1'b1
    } irx_mode_e;

endpackage

// File: rtl/irx_bit_timer.sv
// Module irx_bit_timer
// Divides the system clock into sub-ticks of (div+1) clocks and counts
// TICKS sub-ticks per bit period. Held at sub-tick 0 while run is low.
// restart forces the count back to the start of a period.
// Assumes TICKS is a power of two and that div is stable while running.
module irx_bit_timer #(
    parameter int DIV_W = 8,
    parameter int TICKS = 16,
    localparam int TW   = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic [TW-1:0]    tick_idx,
    output logic             bit_end
);

    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS - 1);

    logic [DIV_W-1:0] sub_q;
    logic             sub_end;

    assign sub_end = (sub_q == div);
    assign bit_end = run && sub_end && (tick_idx == LAST_TICK);

    // Advance the sub-clock and sub-tick counters
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            sub_q    <= '0;
            tick_idx <= '0;
        end else if (sub_end) begin
            sub_q    <= '0;
            tick_idx <= (tick_idx == LAST_TICK) ? '0 : tick_idx + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

endmodule

// File: rtl/irx_rzi_tx.sv
// Module irx_rzi_tx
// Inverted return-to-zero modulator. A zero bit drives a light pulse over
// the first PW sub-ticks of its period; a one bit leaves the line dark.
// Assumes pulse_mode and div change only while idle.
module irx_rzi_tx
    import irx_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int TICKS   = 16,
    parameter int NARROW  = 3,
    parameter int MEDIUM  = 4,
    localparam int TW     = $clog2(TICKS),
    localparam int RUN_W  = DIV_W + TW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  irx_mode_e        mode,
    input  logic [DIV_W-1:0] div,
    input  logic             tx_valid,
    input  logic             tx_bit,
    output logic             tx_next,
    output logic             ir_tx
);

    logic          act_q;
    logic          bit_q;
    logic          load;
    logic [TW-1:0] tick;
    logic          bit_end;
    logic [TW:0]   pw;

    irx_bit_timer #(.DIV_W(DIV_W), .TICKS(TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (act_q),
        .restart  (1'b0),
        .div      (div),
        .tick_idx (tick),
        .bit_end  (bit_end)
    );

    assign pw    = (mode == IRX_MEDIUM) ? (TW+1)'(MEDIUM) : (TW+1)'(NARROW);
    assign load  = tx_valid && (!act_q || bit_end);
    assign ir_tx = act_q && !bit_q && ({1'b0, tick} < pw);

    // Latch a new bit at the start of each period, drop to idle when none
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            bit_q   <= 1'b1;
            tx_next <= 1'b0;
        end else begin
            tx_next <= load;
            if (load) begin
                act_q <= 1'b1;
                bit_q <= tx_bit;
            end else if (bit_end) begin
                act_q <= 1'b0;
            end
        end
    end

    // Checker state: clocks the emitter has already been high in a row
    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] hi_lim;

    assign hi_lim = RUN_W'(pw) * (RUN_W'(div) + 1'b1);

    // Count consecutive high clocks on the emitter
    always_ff @(posedge clk) begin
        if (!rst_n || !ir_tx) hi_run <= '0;
        else                  hi_run <= hi_run + 1'b1;
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ir_tx |-> (hi_run < hi_lim)); // R3 R4

    AST_NEXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_next |=> !tx_next); // R6

endmodule

// File: rtl/irx_rzi_rx.sv
// Module irx_rzi_rx
// Inverted return-to-zero demodulator. Synchronises the detector line,
// finds rising edges and decodes one bit per window: zero if an edge fell
// in it, one otherwise. Every edge restarts the window timer.
// Assumes div is stable while a stream is being received.
module irx_rzi_rx #(
    parameter int DIV_W  = 8,
    parameter int TICKS  = 16,
    parameter int SYNC   = 2,
    localparam int TW    = $clog2(TICKS),
    localparam logic [TW-1:0] HALF = TW'(TICKS / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             ir_rx,
    output logic             rx_valid,
    output logic             rx_bit
);

    logic          line;
    logic          prev_q;
    logic          edge_det;
    logic          act_q;
    logic          seen_q;
    logic [TW-1:0] tick;
    logic          bit_end;

    generate
        if (SYNC > 0) begin : g_sync
            logic [SYNC-1:0] sync_q;
            // Bring the asynchronous detector line into the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= ir_rx;
                    for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
                end
            end
            assign line = sync_q[SYNC-1];
        end else begin : g_direct
            assign line = ir_rx;
        end
    endgenerate

    assign edge_det = line && !prev_q;

    irx_bit_timer #(.DIV_W(DIV_W), .TICKS(TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (act_q),
        .restart  (edge_det),
        .div      (div),
        .tick_idx (tick),
        .bit_end  (bit_end)
    );

    // Track edges, close windows and emit decoded bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            act_q    <= 1'b0;
            seen_q   <= 1'b0;
            rx_valid <= 1'b0;
            rx_bit   <= 1'b1;
        end else begin
            prev_q   <= line;
            rx_valid <= 1'b0;
            if (edge_det) begin
                if (act_q && (tick >= HALF)) begin
                    rx_valid <= 1'b1;
                    rx_bit   <= !seen_q;
                end
                act_q  <= 1'b1;
                seen_q <= 1'b1;
            end else if (act_q && bit_end) begin
                rx_valid <= 1'b1;
                rx_bit   <= !seen_q;
                seen_q   <= 1'b0;
            end
        end
    end

    AST_RX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8

    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && !edge_det) |=> !rx_valid); // R9

    AST_RX_EDGE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && edge_det && (tick >= HALF)) |=> (rx_valid && !rx_bit) || $past(!seen_q)); // R10

endmodule

// File: rtl/irx_rzi_codec.sv
// Module irx_rzi_codec
// Top of the serial infrared bit modulator and demodulator for the two
// slower link rates. Transmit and receive paths are independent; both take
// their bit timing from the shared sub-tick divisor.
// Assumes pulse_mode and tick_div change only while the links are quiet.
module irx_rzi_codec #(
    parameter int DIV_W  = 8,
    parameter int TICKS  = 16,
    parameter int NARROW = 3,
    parameter int MEDIUM = 4,
    parameter int SYNC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_mode,
    input  logic [DIV_W-1:0] tick_div,
    input  logic             tx_valid,
    input  logic             tx_bit,
    output logic             tx_next,
    output logic             ir_tx,
    input  logic             ir_rx,
    output logic             rx_valid,
    output logic             rx_bit
);

    import irx_pkg::*;

    irx_mode_e mode;

    assign mode = irx_mode_e'(pulse_mode);

    irx_rzi_tx #(
        .DIV_W  (DIV_W),
        .TICKS  (TICKS),
        .NARROW (NARROW),
        .MEDIUM (MEDIUM)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .div      (tick_div),
        .tx_valid (tx_valid),
        .tx_bit   (tx_bit),
        .tx_next  (tx_next),
        .ir_tx    (ir_tx)
    );

    irx_rzi_rx #(
        .DIV_W (DIV_W),
        .TICKS (TICKS),
        .SYNC  (SYNC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (tick_div),
        .ir_rx    (ir_rx),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit)
    );

    AST_LOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_next |-> (ir_tx == !$past(tx_bit))); // R1 R2

endmodule

// File: tb/irx_rzi_codec_tb.sv
module irx_rzi_codec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_mode = 1'b0;
    logic [7:0] tick_div = 8'd0;
    logic       tx_valid = 1'b0;
    logic       tx_bit = 1'b1;
    logic       tx_next;
    logic       ir_tx;
    logic       ir_rx;
    logic       rx_valid;
    logic       rx_bit;
    logic       loop_en = 1'b1;
    logic       man_rx = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state
    int m_act = 0;
    int m_pos = 0;
    int m_bit = 1;
    int m_armed = 0;
    int man_armed = 0;
    bit exp_q[$];
    string rx_tag = "R8";

    assign ir_rx = loop_en ? ir_tx : man_rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    irx_rzi_codec u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (pulse_mode),
        .tick_div   (tick_div),
        .tx_valid   (tx_valid),
        .tx_bit     (tx_bit),
        .tx_next    (tx_next),
        .ir_tx      (ir_tx),
        .ir_rx      (ir_rx),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Behavioural transmitter model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_pos = 0; m_armed = 0;
        end else if (m_act != 0 && m_pos < 16*(int'(tick_div)+1) - 1) begin
            m_pos++;
        end else if (tx_valid) begin
            m_act = 1; m_pos = 0; m_bit = int'(tx_bit);
            if (loop_en) begin
                exp_q.push_back(tx_bit);
                if (!tx_bit) m_armed = 1;
            end
        end else begin
            m_act = 0; m_pos = 0;
        end
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog expired: actual cycle %0d expected finish before %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    // Compare every output with the model between edges
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (ir_tx !== 1'b0 || tx_next !== 1'b0 || rx_valid !== 1'b0) begin
                errors++;
                $display("FAIL R11 reset outputs: actual %b%b%b expected 000", ir_tx, tx_next, rx_valid);
            end
        end else begin
            int lim;
            logic e_ir;
            logic e_nx;
            string tg;
            lim  = (pulse_mode ? 4 : 3) * (int'(tick_div) + 1);
            e_ir = (m_act != 0) && (m_bit == 0) && (m_pos < lim);   // R1 R3 R4
            e_nx = (m_act != 0) && (m_pos == 0);                    // R5 R6
            tg = (m_act == 0) ? "R7" : (m_bit != 0) ? "R2" : pulse_mode ? "R4" : "R3";
            checks++;
            if (ir_tx !== e_ir) begin
                errors++;
                $display("FAIL %s ir_tx at pos %0d: actual %b expected %b", tg, m_pos, ir_tx, e_ir);
            end
            checks++;
            if (tx_next !== e_nx) begin
                errors++;
                $display("FAIL R6 tx_next at pos %0d: actual %b expected %b", m_pos, tx_next, e_nx);
            end
            if (rx_valid) begin
                bit e;
                checks++;
                if (m_armed == 0 && man_armed == 0) begin
                    errors++;
                    $display("FAIL R9 bit before first edge: actual %b expected none", rx_bit);
                end else begin
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
                    if (rx_bit !== e) begin
                        errors++;
                        $display("FAIL %s decoded bit: actual %b expected %b", rx_tag, rx_bit, e);
                    end
                end
            end
        end
    end

    task automatic do_reset(input logic md, input logic [7:0] dv, input logic lp);
        @(negedge clk);
        rst_n = 1'b0; tx_valid = 1'b0; man_rx = 1'b0;
        pulse_mode = md; tick_div = dv; loop_en = lp; man_armed = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_empty(input string tg);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s bits left undecoded: actual %0d expected 0", tg, exp_q.size());
        end
    endtask

    // Offer n bits, LSB first, updating the bit after each tx_next
    task automatic send_burst(input int n, input logic [31:0] bits);
        @(negedge clk);
        tx_valid = 1'b1; tx_bit = bits[0];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tx_next) @(negedge clk);
            if (i < n - 1) tx_bit = bits[i+1];
            else tx_valid = 1'b0;
        end
        repeat (48 * (int'(tick_div) + 1) + 10) @(negedge clk);
    endtask

    // Drive detector pulses by hand with a chosen bit period
    task automatic man_send(input int n, input logic [15:0] bits, input int period, input int hi);
        man_armed = 1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(bits[i]);
            for (int c = 0; c < period; c++) begin
                @(negedge clk);
                man_rx = !bits[i] && (c < hi);
            end
        end
        @(negedge clk);
        man_rx = 1'b0;
        repeat (200) @(negedge clk);
    endtask

    initial begin
        // R11 reset state, then R9 idle receiver and R7 idle emitter
        do_reset(1'b0, 8'd0, 1'b1);
        repeat (100) @(negedge clk);
        // R3 narrow pulses, divisor 0, mixed pattern starting with zero
        rx_tag = "R8";
        send_burst(12, 32'b0110_1001_0010);
        expect_empty("R8");
        // R4 medium pulses, divisor 0
        do_reset(1'b1, 8'd0, 1'b1);
        send_burst(10, 32'b11_0000_1010);
        expect_empty("R8");
        // R5 longer sub-ticks, narrow mode
        do_reset(1'b0, 8'd2, 1'b1);
        send_burst(9, 32'b1_1100_0110);
        expect_empty("R8");
        // R5 medium mode, divisor 3, runs of ones
        do_reset(1'b1, 8'd3, 1'b1);
        send_burst(8, 32'b1110_1110);
        expect_empty("R8");
        // R10 slow far end: edges land early in the window
        do_reset(1'b0, 8'd1, 1'b0);
        rx_tag = "R10";
        man_send(11, 16'b100_0111_0010, 34, 6);
        expect_empty("R10");
        // R10 fast far end: edges land late in the window
        do_reset(1'b0, 8'd1, 1'b0);
        man_send(4, 16'b0100, 30, 6);
        expect_empty("R10");
        summary();
        $finish;
    end

endmodule